// File: doc/BRIEF.md
# Dual-Clock FIFO with Preset Threshold Flags

This block is a one-way queue of 64 words, each 36 bits wide. It connects a producer and a consumer that run on separate clocks. The two clocks may be unrelated or may be the same clock. The producer side owns the write clock, the write strobe and two active-low flags: full and almost-full. The consumer side owns the read clock, the read strobe, a registered data output and two active-low flags: empty and almost-empty. Each flag is held in a flip-flop clocked by the port that uses it.

Read and write positions are 7-bit counters. Each counter crosses to the other domain as a gray code. A first capture flop sits in the far domain, and each flag flop is computed from that captured value and the local pointer's next value. As a result, a flag that releases always does so two edges of the local clock after the event on the far side.

The two almost flags share one threshold. The threshold is one of four preset values, picked by a 2-bit select input. Each domain samples the select while reset is active and on the first edge of its own clock after reset is released. After that it keeps the value until the next reset.

Top module: `dc_flag_fifo`

## Requirements
- R1: A word read from the queue appears on `rd_data` after the read-clock edge that accepts the read. Words come out in the order they were accepted, and up to 64 words can be held at once. `rd_data` is 0 after reset until the first accepted read.
- R2: `empty_n` is 0 while reset is active. After a word is accepted into an empty queue, `empty_n` stays 0 on the first read-clock edge and becomes 1 on the second read-clock edge.
- R3: `full_n` is 0 while reset is active. It stays 0 on the first write-clock edge after reset is released and becomes 1 on the second.
- R4: `full_n` is 0 while 64 words are held, as seen by the write side. A write strobe while `full_n` is 0 is dropped: that word never appears on `rd_data`, and the following words keep their order.
- R5: A read strobe while `empty_n` is 0 is ignored: `rd_data` keeps its value, and no word is lost or repeated.
- R6: `aempty_n` is 0 whenever the word count seen by the read side is at or below the threshold T. Otherwise it is 1.
- R7: `afull_n` is 0 whenever the number of free slots seen by the write side is at or below T. Otherwise it is 1.
- R8: T is 8, 16, 32 or 60 for `ofs_sel` = 00, 01, 10 or 11. The value is sampled during reset and at the release edge. Changes to `ofs_sel` after release have no effect until the next reset.
- R9: Asserting `rst_n` low forces `empty_n`=0, `full_n`=0, `aempty_n`=0, `afull_n`=1 and `rd_data`=0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset. Asserts asynchronously; each domain syncs its release. |
| ofs_sel | input | 2 | Threshold preset select, sampled around reset release. |
| wclk | input | 1 | Write-side clock. |
| wr_en | input | 1 | Write strobe. Accepted only while `full_n` is 1. |
| wr_data | input | 36 | Word to enqueue. |
| full_n | output | 1 | Low when the queue is full (write domain). |
| afull_n | output | 1 | Low when free slots are at or below T (write domain). |
| rclk | input | 1 | Read-side clock. |
| rd_en | input | 1 | Read strobe. Accepted only while `empty_n` is 1. |
| rd_data | output | 36 | Most recently dequeued word. |
| empty_n | output | 1 | Low when the queue is empty (read domain). |
| aempty_n | output | 1 | Low when the stored count is at or below T (read domain). |

## Verification
The hardest state to reach is exactly 64 stored words. At that point the two pointers have equal low bits and differ only in the top bit, and the flags report it only after the two-edge lag. The bench gets there by writing well past capacity with reads held off, then reads well past empty. This exercises the dropped write and the ignored read.

It then runs long streams with overlapping, pseudo-random read and write strobes, so the count crosses each threshold from both directions. The whole sequence repeats for all four presets, with the select changed after release. One run also applies reset in the middle of traffic.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic [1:0] {
    OFS_NEAR  = 2'b00,
    OFS_QUART = 2'b01,
    OFS_HALF  = 2'b10,
    OFS_DEEP  = 2'b11
  } ofs_sel_e;

  // binary -> reflected gray
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // reflected gray -> binary, prefix xor from the top
  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // threshold preset chosen by the select pins
  function automatic logic [7:0] offset_preset(input logic [1:0] s);
    case (ofs_sel_e'(s))
      OFS_NEAR:  return 8'd8;
      OFS_QUART: return 8'd16;
      OFS_HALF:  return 8'd32;
      default:   return 8'd60;
    endcase
  endfunction

endpackage

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] stage1,
  output logic [W-1:0] seen_bin
);
  import dcf_pkg::*;

  // first capture flop; the flag flops downstream form the second stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage1 <= '0;
    else        stage1 <= gray_in;
  end

  // settled binary copy of the far pointer, same age as the flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_bin <= '0;
    else        seen_bin <= W'(from_gray(32'(stage1)));
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ofs_sel,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   rgray_in,
  output logic [ADDR_W:0]   wgray_out,
  output logic [ADDR_W-1:0] waddr,
  output logic              wr_fire,
  output logic              full_n,
  output logic              afull_n
);
  import dcf_pkg::*;

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  // release synchronizer for this domain
  logic rel_s1, rel_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_s1 <= 1'b0;
      rel_s2 <= 1'b0;
    end else begin
      rel_s1 <= 1'b1;
      rel_s2 <= rel_s1;
    end
  end

  // threshold: keeps loading until the release reaches this domain
  logic [7:0] ofs_q;
  always_ff @(posedge clk) begin
    if (!rel_s1) ofs_q <= offset_preset(ofs_sel);
  end

  logic [PTR_W-1:0] rsync1, rseen;
  dcf_ptr_sync #(.W(PTR_W)) u_rsync (
    .clk      (clk),
    .rst_n    (rst_n),
    .gray_in  (rgray_in),
    .stage1   (rsync1),
    .seen_bin (rseen)
  );

  logic [PTR_W-1:0] wptr, wnext, rq, used_nx, free_nx;
  assign wr_fire = wr_en & full_n;
  assign wnext   = wptr + PTR_W'(wr_fire);
  assign rq      = PTR_W'(from_gray(32'(rsync1)));
  assign used_nx = wnext - rq;
  assign free_nx = PTR_W'(DEPTH) - used_nx;
  assign waddr   = wptr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr      <= '0;
      wgray_out <= '0;
      full_n    <= 1'b0;
      afull_n   <= 1'b1;
    end else begin
      wptr      <= wnext;
      wgray_out <= PTR_W'(to_gray(32'(wnext)));
      full_n    <= rel_s1 && (used_nx != PTR_W'(DEPTH));
      afull_n   <= 32'(free_nx) > 32'(ofs_q);
    end
  end

  // R4: occupancy against the settled read pointer never exceeds the depth
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    PTR_W'(wptr - rseen) <= PTR_W'(DEPTH));

  // R1: the published pointer moves by at most one gray bit per edge
  p_gray_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray_out ^ $past(wgray_out)) <= 1);

  // R7: once settled, a full queue is also almost full
  p_full_afull_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_s2 && !full_n) |-> !afull_n);

  // R8: threshold frozen after release
  p_ofs_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_s1 |=> $stable(ofs_q));
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ofs_sel,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   wgray_in,
  output logic [ADDR_W:0]   rgray_out,
  output logic [ADDR_W-1:0] raddr,
  output logic              rd_fire,
  output logic              empty_n,
  output logic              aempty_n
);
  import dcf_pkg::*;

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic rel_s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_s1 <= 1'b0;
    else        rel_s1 <= 1'b1;
  end

  logic [7:0] ofs_q;
  always_ff @(posedge clk) begin
    if (!rel_s1) ofs_q <= offset_preset(ofs_sel);
  end

  logic [PTR_W-1:0] wsync1, wseen;
  dcf_ptr_sync #(.W(PTR_W)) u_wsync (
    .clk      (clk),
    .rst_n    (rst_n),
    .gray_in  (wgray_in),
    .stage1   (wsync1),
    .seen_bin (wseen)
  );

  logic [PTR_W-1:0] rptr, rnext, wq, cnt_nx;
  assign rd_fire = rd_en & empty_n;
  assign rnext   = rptr + PTR_W'(rd_fire);
  assign wq      = PTR_W'(from_gray(32'(wsync1)));
  assign cnt_nx  = wq - rnext;
  assign raddr   = rptr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr      <= '0;
      rgray_out <= '0;
      empty_n   <= 1'b0;
      aempty_n  <= 1'b0;
    end else begin
      rptr      <= rnext;
      rgray_out <= PTR_W'(to_gray(32'(rnext)));
      empty_n   <= (wq != rnext);
      aempty_n  <= 32'(cnt_nx) > 32'(ofs_q);
    end
  end

  // R5: the read pointer never passes the settled write pointer
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    PTR_W'(wseen - rptr) <= PTR_W'(DEPTH));

  // R6: an empty queue is also almost empty
  p_empty_aempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);

  // R8: threshold frozen after release
  p_ofs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_s1 |=> $stable(ofs_q));
endmodule

// File: rtl/dc_flag_fifo.sv
module dc_flag_fifo #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6
) (
  input  logic              rst_n,
  input  logic [1:0]        ofs_sel,
  input  logic              wclk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full_n,
  output logic              afull_n,
  input  logic              rclk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0]  wgray, rgray;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wr_fire, rd_fire;

  dcf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk       (wclk),
    .rst_n     (rst_n),
    .ofs_sel   (ofs_sel),
    .wr_en     (wr_en),
    .rgray_in  (rgray),
    .wgray_out (wgray),
    .waddr     (waddr),
    .wr_fire   (wr_fire),
    .full_n    (full_n),
    .afull_n   (afull_n)
  );

  dcf_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (rclk),
    .rst_n     (rst_n),
    .ofs_sel   (ofs_sel),
    .rd_en     (rd_en),
    .wgray_in  (wgray),
    .rgray_out (rgray),
    .raddr     (raddr),
    .rd_fire   (rd_fire),
    .empty_n   (empty_n),
    .aempty_n  (aempty_n)
  );

  dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wclk  (wclk),
    .we    (wr_fire),
    .waddr (waddr),
    .wdata (wr_data),
    .rclk  (rclk),
    .rst_n (rst_n),
    .re    (rd_fire),
    .raddr (raddr),
    .rdata (rd_data)
  );
endmodule

// File: tb/dc_flag_fifo_tb_top.sv
module dc_flag_fifo_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  sel = 2'b00;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic [35:0] rd_data;
  logic        full_n, afull_n, empty_n, aempty_n;

  dc_flag_fifo dut_i (
    .rst_n (rst_n), .ofs_sel (sel),
    .wclk (clk), .wr_en (wr_en), .wr_data (wr_data),
    .full_n (full_n), .afull_n (afull_n),
    .rclk (clk), .rd_en (rd_en), .rd_data (rd_data),
    .empty_n (empty_n), .aempty_n (aempty_n)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  int dcount = 0;

  function automatic int preset(input logic [1:0] s);
    return (s == 2'b11) ? 60 : (8 << s);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: totals, one-edge-old remote views, a queue
  int wt = 0, rt = 0, ws1 = 0, rs1 = 0, x = 8;
  bit m_s1 = 0, m_e = 0, m_f = 0, m_ae = 0, m_af = 1;
  logic [35:0] m_rd = '0;
  logic [35:0] q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt = 0; rt = 0; ws1 = 0; rs1 = 0; m_s1 = 0;
      m_e = 0; m_f = 0; m_ae = 0; m_af = 1; m_rd = '0;
      q.delete();
      x = preset(sel);
    end else begin
      bit wf, rf;
      int nw, nr;
      wf = wr_en && m_f;
      rf = rd_en && m_e;
      nw = wt + int'(wf);
      nr = rt + int'(rf);
      if (wf) q.push_back(wr_data);
      if (rf) m_rd = q.pop_front();
      m_e  = (ws1 != nr);
      m_ae = (ws1 - nr) > x;
      m_f  = m_s1 && ((nw - rs1) != 64);
      m_af = (64 - (nw - rs1)) > x;
      if (!m_s1) x = preset(sel);
      m_s1 = 1'b1;
      ws1 = wt; rs1 = rt; wt = nw; rt = nr;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(empty_n === m_e,   "R2 R5 empty_n",  36'(empty_n),  36'(m_e));
      chk(full_n === m_f,    "R3 R4 full_n",   36'(full_n),   36'(m_f));
      chk(aempty_n === m_ae, "R6 R8 aempty_n", 36'(aempty_n), 36'(m_ae));
      chk(afull_n === m_af,  "R7 R8 afull_n",  36'(afull_n),  36'(m_af));
      chk(rd_data === m_rd,  "R1 R4 R5 rd_data", rd_data, m_rd);
    end
  end

  task automatic cyc(input bit w, input bit r);
    @(negedge clk); #1;
    wr_en = w; rd_en = r;
    dcount++;
    wr_data = {4'(dcount >> 8), 32'(dcount) * 32'h9E37_79B1};
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk); #1;
    wr_en = 0; rd_en = 0; sel = s;
    rst_n = 0;
    #1;
    chk(empty_n === 1'b0,  "R9 empty_n forced",  36'(empty_n),  36'd0);
    chk(full_n === 1'b0,   "R9 full_n forced",   36'(full_n),   36'd0);
    chk(aempty_n === 1'b0, "R9 aempty_n forced", 36'(aempty_n), 36'd0);
    chk(afull_n === 1'b1,  "R9 afull_n forced",  36'(afull_n),  36'd1);
    chk(rd_data === '0,    "R9 rd_data cleared", rd_data, '0);
    repeat (3) cyc(0, 0);
    @(negedge clk); #1;
    rst_n = 1;
    cyc(0, 0);
    chk(full_n === 1'b0, "R3 full_n low on first edge", 36'(full_n), 36'd0);
    cyc(0, 0);
    chk(full_n === 1'b1, "R3 full_n high on second edge", 36'(full_n), 36'd1);
    sel = ~s;  // R8: later changes must not matter
  endtask

  initial begin
    for (int p = 0; p < 4; p++) begin
      logic [1:0] s;
      int t;
      logic [15:0] lf;
      s = 2'(p);
      t = preset(s);
      do_reset(s);

      // R2: first word into an empty queue
      cyc(1, 0);
      cyc(0, 0);
      chk(empty_n === 1'b0, "R2 empty_n after write edge", 36'(empty_n), 36'd0);
      cyc(0, 0);
      chk(empty_n === 1'b0, "R2 empty_n first read edge", 36'(empty_n), 36'd0);
      cyc(0, 0);
      chk(empty_n === 1'b1, "R2 empty_n second read edge", 36'(empty_n), 36'd1);

      // R4: overfill
      repeat (70) cyc(1, 0);
      repeat (4) cyc(0, 0);
      chk(full_n === 1'b0,  "R4 full_n at 64 words", 36'(full_n), 36'd0);
      chk(afull_n === 1'b0, "R7 afull_n at 64 words", 36'(afull_n), 36'd0);

      // R5: overdrain
      repeat (70) cyc(0, 1);
      repeat (4) cyc(0, 0);
      chk(empty_n === 1'b0,  "R5 empty_n drained", 36'(empty_n), 36'd0);
      chk(aempty_n === 1'b0, "R6 aempty_n drained", 36'(aempty_n), 36'd0);

      // R8: threshold boundary for this preset
      repeat (t) cyc(1, 0);
      repeat (4) cyc(0, 0);
      chk(aempty_n === 1'b0, "R8 aempty_n at T words", 36'(aempty_n), 36'd0);
      cyc(1, 0);
      repeat (4) cyc(0, 0);
      chk(aempty_n === 1'b1, "R8 aempty_n at T+1 words", 36'(aempty_n), 36'd1);
      chk(afull_n === ((64 - (t + 1)) > t), "R8 afull_n at T+1 words",
          36'(afull_n), 36'((64 - (t + 1)) > t));
      repeat (70) cyc(0, 1);

      // mixed traffic
      lf = 16'hACE1 ^ 16'(p * 16'h1357);
      for (int i = 0; i < 400; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (i < 200) cyc(lf[0] | lf[3], lf[1] & lf[5]);
        else         cyc(lf[0] & lf[3], lf[1] | lf[5]);
        if (p == 2 && i == 120) do_reset(s);
      end
      repeat (70) cyc(0, 1);
      repeat (4) cyc(0, 0);
    end
    @(negedge clk); #1;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R1 watchdog act=%h exp=%h", 36'd0, 36'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule